// File: doc/BRIEF.md
# Chained DMA Channel Sequencer

This block is the control half of one DMA channel. It produces a stream of transfer addresses, and each address waits on a ready handshake. The data path that moves the words lives elsewhere. The block works from a set of working registers: start address, transfer count, configuration word and link pointer. Software loads these registers directly and then pulses `go`. In the descriptor flows, the channel instead pulls its parameters from memory over a one-word-per-request read port. When a buffer finishes, the channel chains to the next buffer without any software action.

Every buffer is one-dimensional. The address moves by a signed 16-bit stride after each accepted transfer. The flow selected in the configuration word decides what happens when a buffer ends:
- stop;
- reload the original start and count, and keep running;
- fetch a one-word array entry;
- fetch a linked descriptor. A linked descriptor is either four words (full) or two words (ring).

Interrupts can be raised at buffer completion, at the halfway point, or at both.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset `busy`, `xfer_req`, `mem_rd_req`, `irq_done`, `irq_half` and `cfg_err` are all low.
- R2: With flow 00 (stop), the channel issues exactly `length` transfers and then drops `busy`. `busy` falls at the edge that accepts the last transfer.
- R3: Transfer k (counting from 0) of a buffer uses address start + k·stride. The stride is configuration bits [31:16], read as signed. Negative and zero strides are allowed, and zero repeats the same address.
- R4: With flow 01 (autobuffer), the edge that accepts the last transfer reloads the programmed start address and count. The next transfer then reuses the start address, and the channel stays busy.
- R5: When configuration bit 2 is set, `irq_done` is high for the one cycle after the edge that accepts a buffer's last transfer. When bit 2 is clear, `irq_done` never rises.
- R6: When configuration bit 3 is set and length ≥ 2, `irq_half` is high for the one cycle after the edge that accepts transfer number floor(length/2), counting from 1. In all other cases it stays low.
- R7: Flow 11 with configuration bit 4 clear reads four consecutive words starting at the link pointer, in this order: next pointer, start, length, configuration. The loaded configuration then governs the buffer and what follows it.
- R8: Flow 11 with bit 4 set reads two consecutive words: next pointer, then start. Length and configuration are kept from before, so links that close on themselves run as an endless ring.
- R9: Flow 10 reads one word, the start address, from the link pointer, and advances the pointer by one. Length and configuration are kept. A fetched word of all ones ends the channel, and no buffer is run for it.
- R10: A register write (`reg_wr_sel`: 0 start, 1 length, 2 configuration, 3 link pointer) while `busy` is high changes nothing. It sets `cfg_err`, which stays set until reset.
- R11: While `xfer_req` is high and `xfer_rdy` is low, the request and its address hold. The same holds for `mem_rd_req`, `mem_rd_addr` and `mem_rd_valid`.
- R12: `busy` rises at the edge that samples `go` and stays high until the channel stops. While `busy` is low, no requests are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 start, 1 length, 2 config, 3 link pointer |
| reg_wr_data | input | 32 | Register write data |
| go | input | 1 | Start pulse, honoured only while idle |
| mem_rd_req | output | 1 | Descriptor word read request |
| mem_rd_addr | output | AW | Descriptor word address |
| mem_rd_valid | input | 1 | Read data valid; completes the request |
| mem_rd_data | input | 32 | Read data |
| xfer_req | output | 1 | Transfer request |
| xfer_addr | output | AW | Transfer address |
| xfer_rdy | input | 1 | Transfer accepted when high with `xfer_req` |
| irq_done | output | 1 | Buffer-complete pulse |
| irq_half | output | 1 | Halfway pulse |
| busy | output | 1 | Channel active |
| cfg_err | output | 1 | Sticky flag for a write made while busy |

## Verification
In register mode, the first `xfer_req` appears two edges after the edge that samples `go`: one edge to load the address generator, one to enter the run state. After the last descriptor word is read, the first request again comes two edges later. `irq_done` and `irq_half` are due exactly one edge after the accepting handshake, and `busy` falls on that same accepting edge. The bench drives inputs and samples outputs on falling edges. Each address is checked at the falling edge just before the edge that will accept it. The interrupts and `busy` are checked at the next falling edge. Sweeps cover lengths, signed strides, interrupt selections and both steady and stalling ready patterns.

// File: rtl/dma_chan_pkg.sv
// Shared types and configuration-word field helpers for the DMA channel.
// Assumes a fixed 32-bit register/descriptor word.
package dma_chan_pkg;

    localparam int WORD_W   = 32;
    localparam int STRIDE_W = 16;

    // Register select codes on the write port.
    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_LEN   = 2'd1;
    localparam logic [1:0] SEL_CFG   = 2'd2;
    localparam logic [1:0] SEL_PTR   = 2'd3;

    typedef enum logic [1:0] {
        FLOW_STOP  = 2'b00,
        FLOW_AUTO  = 2'b01,
        FLOW_ARRAY = 2'b10,
        FLOW_LIST  = 2'b11
    } flow_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LOAD  = 2'd2,
        ST_RUN   = 2'd3
    } state_e;

    typedef enum logic [1:0] {
        FMT_ARRAY = 2'd0,
        FMT_RING  = 2'd1,
        FMT_FULL  = 2'd2
    } fmt_e;

    function automatic flow_e cfg_flow(input logic [WORD_W-1:0] c);
        return flow_e'(c[1:0]);
    endfunction

    function automatic logic cfg_irq_done(input logic [WORD_W-1:0] c);
        return c[2];
    endfunction

    function automatic logic cfg_irq_half(input logic [WORD_W-1:0] c);
        return c[3];
    endfunction

    function automatic logic cfg_ring(input logic [WORD_W-1:0] c);
        return c[4];
    endfunction

    function automatic logic [STRIDE_W-1:0] cfg_stride(input logic [WORD_W-1:0] c);
        return c[WORD_W-1 -: STRIDE_W];
    endfunction

    function automatic logic [2:0] fmt_words(input fmt_e f);
        case (f)
            FMT_ARRAY: return 3'd1;
            FMT_RING:  return 3'd2;
            default:   return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_desc_fetch.sv
// Descriptor word fetcher.
// Purpose: on a start pulse, read nwords consecutive words from base,
//   one request at a time. Each returned word is reported with its index,
//   and the final word is flagged.
// Assumes: a request completes in the cycle mem_rd_valid is high, and
//   start is only pulsed while the fetcher is inactive.
module dma_desc_fetch #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base,
    input  logic [2:0]    nwords,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_valid,
    output logic          word_vld,
    output logic [1:0]    word_idx,
    output logic          last
);

    logic          active_q;
    logic [2:0]    idx_q;
    logic [2:0]    n_q;
    logic [AW-1:0] base_q;
    logic [2:0]    idx_inc;

    assign idx_inc = idx_q + 3'd1;

    // Track the active fetch and the index of the word being read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            n_q      <= '0;
            base_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            n_q      <= nwords;
            base_q   <= base;
        end else if (active_q && mem_rd_valid) begin
            idx_q <= idx_inc;
            if (idx_inc == n_q) begin
                active_q <= 1'b0;
            end
        end
    end

    assign mem_rd_req  = active_q;
    assign mem_rd_addr = base_q + AW'(idx_q);
    assign word_vld    = active_q && mem_rd_valid;
    assign word_idx    = idx_q[1:0];
    assign last        = word_vld && (idx_inc == n_q);

    p_idx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (idx_q < n_q));

    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

endmodule

// File: rtl/dma_addr_gen.sv
// One-dimensional address generator.
// Purpose: hold the current address and the transfer index of a buffer.
//   The address steps by a signed stride on each accepted transfer, and the
//   generator flags the last and the halfway transfers.
// Assumes: load has priority over step. A length of zero stands for
//   2**LW transfers.
module dma_addr_gen #(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [LW-1:0] load_len,
    input  logic [SW-1:0] stride,
    input  logic          step,
    output logic [AW-1:0] cur_addr,
    output logic          last,
    output logic          half_hit
);

    logic [AW-1:0] cur_q;
    logic [LW-1:0] idx_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] idx_inc;
    logic [AW-1:0] stride_ext;

    assign stride_ext = AW'(signed'(stride));
    assign idx_inc    = idx_q + LW'(1);

    // Load a new buffer, or advance address and index on a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            idx_q <= '0;
            len_q <= '0;
        end else if (load) begin
            cur_q <= load_addr;
            idx_q <= '0;
            len_q <= load_len;
        end else if (step) begin
            cur_q <= cur_q + stride_ext;
            idx_q <= idx_inc;
        end
    end

    assign cur_addr = cur_q;
    assign last     = (idx_inc == len_q);
    assign half_hit = (len_q[LW-1:1] != '0) && (idx_inc == (len_q >> 1));

    p_load_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur_addr == $past(load_addr)));

endmodule

// File: rtl/dma_chan_ctrl.sv
// DMA channel controller (top).
// Purpose: holds the working registers and runs the channel state machine
//   (idle, descriptor fetch, load, run). It issues transfer requests through
//   the address generator, chains buffers according to the flow field, and
//   raises the completion and halfway interrupt pulses.
// Assumes: descriptor memory returns one word per request. Register writes
//   are accepted only while idle.
module dma_chan_ctrl #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [1:0]    reg_wr_sel,
    input  logic [31:0]   reg_wr_data,
    input  logic          go,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_valid,
    input  logic [31:0]   mem_rd_data,
    output logic          xfer_req,
    output logic [AW-1:0] xfer_addr,
    input  logic          xfer_rdy,
    output logic          irq_done,
    output logic          irq_half,
    output logic          busy,
    output logic          cfg_err
);
    import dma_chan_pkg::*;

    state_e              state_q, state_d;
    fmt_e                fmt_q, fmt_next;
    logic [AW-1:0]       start_q;
    logic [LW-1:0]       len_q;
    logic [WORD_W-1:0]   cfg_q;
    logic [AW-1:0]       ptr_q;
    logic                err_q;
    logic                irq_done_q;
    logic                irq_half_q;
    flow_e               flow;
    logic                step;
    logic                done_buf;
    logic                fetch_go;
    logic                ag_load;
    logic                ag_last;
    logic                ag_half;
    logic [AW-1:0]       ag_addr;
    logic                fe_vld;
    logic [1:0]          fe_idx;
    logic                fe_last;
    logic                sentinel;

    assign flow     = cfg_flow(cfg_q);
    assign step     = (state_q == ST_RUN) && xfer_rdy;
    assign done_buf = step && ag_last;
    assign sentinel = fe_last && (fmt_q == FMT_ARRAY) && (mem_rd_data == '1);

    // Choose the descriptor format for the next fetch from the live config.
    always_comb begin
        if (flow == FLOW_ARRAY)    fmt_next = FMT_ARRAY;
        else if (cfg_ring(cfg_q))  fmt_next = FMT_RING;
        else                       fmt_next = FMT_FULL;
    end

    assign fetch_go = cfg_q[1] &&
                      (((state_q == ST_IDLE) && go) || done_buf);
    assign ag_load  = (state_q == ST_LOAD) ||
                      (done_buf && (flow == FLOW_AUTO));

    // Next-state logic for the channel sequencer.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (go) state_d = cfg_q[1] ? ST_FETCH : ST_LOAD;
            ST_FETCH: if (fe_last) state_d = sentinel ? ST_IDLE : ST_LOAD;
            ST_LOAD:  state_d = ST_RUN;
            ST_RUN: begin
                if (done_buf) begin
                    case (flow)
                        FLOW_STOP: state_d = ST_IDLE;
                        FLOW_AUTO: state_d = ST_RUN;
                        default:   state_d = ST_FETCH;
                    endcase
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and latched fetch format.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fmt_q   <= FMT_FULL;
        end else begin
            state_q <= state_d;
            if (fetch_go) fmt_q <= fmt_next;
        end
    end

    // Working registers: software writes while idle, descriptor words while fetching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            len_q   <= '0;
            cfg_q   <= '0;
            ptr_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            if (reg_wr_en && (state_q != ST_IDLE)) begin
                err_q <= 1'b1;
            end else if (reg_wr_en) begin
                case (reg_wr_sel)
                    SEL_START: start_q <= AW'(reg_wr_data);
                    SEL_LEN:   len_q   <= LW'(reg_wr_data);
                    SEL_CFG:   cfg_q   <= reg_wr_data;
                    default:   ptr_q   <= AW'(reg_wr_data);
                endcase
            end
            if (fe_vld) begin
                case (fmt_q)
                    FMT_ARRAY: begin
                        start_q <= AW'(mem_rd_data);
                        ptr_q   <= ptr_q + AW'(1);
                    end
                    FMT_RING: begin
                        if (fe_idx == 2'd0) ptr_q   <= AW'(mem_rd_data);
                        else                start_q <= AW'(mem_rd_data);
                    end
                    default: begin
                        case (fe_idx)
                            2'd0:    ptr_q   <= AW'(mem_rd_data);
                            2'd1:    start_q <= AW'(mem_rd_data);
                            2'd2:    len_q   <= LW'(mem_rd_data);
                            default: cfg_q   <= mem_rd_data;
                        endcase
                    end
                endcase
            end
        end
    end

    // Single-cycle interrupt pulses, registered off the accepting handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_done_q <= 1'b0;
            irq_half_q <= 1'b0;
        end else begin
            irq_done_q <= done_buf && cfg_irq_done(cfg_q);
            irq_half_q <= step && ag_half && cfg_irq_half(cfg_q);
        end
    end

    dma_desc_fetch #(.AW(AW)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (fetch_go),
        .base         (ptr_q),
        .nwords       (fmt_words(fmt_next)),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .word_vld     (fe_vld),
        .word_idx     (fe_idx),
        .last         (fe_last)
    );

    dma_addr_gen #(.AW(AW), .LW(LW), .SW(STRIDE_W)) u_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ag_load),
        .load_addr (start_q),
        .load_len  (len_q),
        .stride    (cfg_stride(cfg_q)),
        .step      (step),
        .cur_addr  (ag_addr),
        .last      (ag_last),
        .half_hit  (ag_half)
    );

    assign xfer_req  = (state_q == ST_RUN);
    assign xfer_addr = ag_addr;
    assign busy      = (state_q != ST_IDLE);
    assign cfg_err   = err_q;
    assign irq_done  = irq_done_q;
    assign irq_half  = irq_half_q;

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!xfer_req && !mem_rd_req));

    p_xfer_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_rdy) |=> (xfer_req && $stable(xfer_addr)));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    p_busy_write_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && busy) |=> cfg_err);

    p_done_on_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> $past(xfer_req && xfer_rdy));

    p_half_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_half && irq_done));

    p_linear_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_rdy && ag_last && (flow == FLOW_STOP)) |=> !busy);

endmodule

// File: tb/test_dma_chan_ctrl.sv
module test_dma_chan_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = '0;
    logic [31:0] reg_wr_data = '0;
    logic        go = 1'b0;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;
    logic        xfer_req;
    logic [31:0] xfer_addr;
    logic        xfer_rdy = 1'b0;
    logic        irq_done;
    logic        irq_half;
    logic        busy;
    logic        cfg_err;

    logic [31:0] mem [0:63];
    logic        mem_stall = 1'b0;
    logic        rdy_stall = 1'b0;
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    always @(negedge clk) cyc <= cyc + 1;

    assign mem_rd_data  = mem[mem_rd_addr[5:0]];
    assign mem_rd_valid = mem_rd_req && (!mem_stall || cyc[0]);

    dma_chan_ctrl i_dma_chan_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_en    (reg_wr_en),
        .reg_wr_sel   (reg_wr_sel),
        .reg_wr_data  (reg_wr_data),
        .go           (go),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .xfer_req     (xfer_req),
        .xfer_addr    (xfer_addr),
        .xfer_rdy     (xfer_rdy),
        .irq_done     (irq_done),
        .irq_half     (irq_half),
        .busy         (busy),
        .cfg_err      (cfg_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input int flow, input int sel,
                                           input bit ring, input int stride);
        logic [31:0] s = 32'(stride);
        return {s[15:0], 11'd0, ring, 2'(sel), 2'(flow)};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        xfer_rdy = 1'b0;
        go = 1'b0;
        reg_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wr_sel = sel;
        reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Pulse go for one edge and confirm busy rose on that edge (R12).
    task automatic start_chan();
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(busy == 1'b1, "R12", "busy after go", 32'(busy), 32'd1);
    endtask

    // Follow one buffer: check each accepted address (R3) and the interrupt
    // pulses one cycle after each accept (R5, R6).
    task automatic watch_buffer(input logic [31:0] start, input int len,
                                input int stride, input int sel, input string req);
        int  got = 0;
        int  guard = 0;
        int  pidx = 0;
        bit  prev = 1'b0;
        bit  exp_d;
        bit  exp_h;
        while (got < len && guard < 400) begin
            @(negedge clk);
            exp_d = prev && sel[0] && (pidx == len);
            exp_h = prev && sel[1] && (len >= 2) && (pidx == len / 2);
            chk(irq_done == exp_d, "R5", {req, " irq_done"}, 32'(irq_done), 32'(exp_d));
            chk(irq_half == exp_h, "R6", {req, " irq_half"}, 32'(irq_half), 32'(exp_h));
            xfer_rdy = rdy_stall ? (cyc % 3 != 1) : 1'b1;
            prev = 1'b0;
            if (xfer_req && xfer_rdy) begin
                chk(xfer_addr == start + 32'(got * stride), "R3", {req, " address"},
                    xfer_addr, start + 32'(got * stride));
                got++;
                prev = 1'b1;
                pidx = got;
            end
            guard++;
        end
        chk(got == len, req, "transfer count", 32'(got), 32'(len));
        @(negedge clk);
        xfer_rdy = 1'b0;
        exp_d = prev && sel[0] && (pidx == len);
        exp_h = prev && sel[1] && (len >= 2) && (pidx == len / 2);
        chk(irq_done == exp_d, "R5", {req, " final irq_done"}, 32'(irq_done), 32'(exp_d));
        chk(irq_half == exp_h, "R6", {req, " final irq_half"}, 32'(irq_half), 32'(exp_h));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int strides [4] = '{-3, 0, 1, 2};
        for (int i = 0; i < 64; i++) mem[i] = '0;
        do_reset();
        @(negedge clk);
        // R1: quiet reset state
        chk(busy == 0, "R1", "busy", 32'(busy), 0);
        chk(xfer_req == 0, "R1", "xfer_req", 32'(xfer_req), 0);
        chk(mem_rd_req == 0, "R1", "mem_rd_req", 32'(mem_rd_req), 0);
        chk(irq_done == 0 && irq_half == 0, "R1", "irqs", {30'd0, irq_half, irq_done}, 0);
        chk(cfg_err == 0, "R1", "cfg_err", 32'(cfg_err), 0);

        // R2/R3/R5/R6: linear sweep over length, stride, irq select, ready pattern
        for (int ln = 1; ln <= 5; ln++) begin
            for (int si = 0; si < 4; si++) begin
                for (int sel = 0; sel < 4; sel++) begin
                    rdy_stall = ((ln + sel) % 2) == 1;
                    write_reg(2'd0, 32'd1000 + 32'(ln * 10));
                    write_reg(2'd1, 32'(ln));
                    write_reg(2'd2, mk_cfg(0, sel, 1'b0, strides[si]));
                    start_chan();
                    watch_buffer(32'd1000 + 32'(ln * 10), ln, strides[si], sel, "R2");
                    chk(busy == 0 && xfer_req == 0, "R2", "stopped after buffer",
                        {30'd0, busy, xfer_req}, 0);
                end
            end
        end

        // R4 and R10: autobuffer reload; a write while busy is ignored
        rdy_stall = 1'b0;
        write_reg(2'd0, 32'd2000);
        write_reg(2'd1, 32'd3);
        write_reg(2'd2, mk_cfg(1, 1, 1'b0, 4));
        start_chan();
        watch_buffer(32'd2000, 3, 4, 1, "R4");
        chk(busy == 1, "R4", "busy after reload", 32'(busy), 1);
        write_reg(2'd1, 32'd7);
        chk(cfg_err == 1, "R10", "cfg_err after busy write", 32'(cfg_err), 1);
        rdy_stall = 1'b1;
        watch_buffer(32'd2000, 3, 4, 1, "R10");
        watch_buffer(32'd2000, 3, 4, 1, "R4");
        chk(cfg_err == 1, "R10", "cfg_err sticky", 32'(cfg_err), 1);
        do_reset();
        @(negedge clk);
        chk(cfg_err == 0, "R10", "cfg_err cleared by reset", 32'(cfg_err), 0);

        // R7: four-word linked descriptors, chain then stop
        mem[8]  = 32'd12; mem[9]  = 32'd200; mem[10] = 32'd2; mem[11] = mk_cfg(3, 1, 1'b0, 1);
        mem[12] = 32'd0;  mem[13] = 32'd300; mem[14] = 32'd3; mem[15] = mk_cfg(0, 2, 1'b0, -1);
        mem_stall = 1'b1;
        rdy_stall = 1'b0;
        write_reg(2'd3, 32'd8);
        write_reg(2'd2, mk_cfg(3, 0, 1'b0, 0));
        start_chan();
        watch_buffer(32'd200, 2, 1, 1, "R7");
        watch_buffer(32'd300, 3, -1, 2, "R7");
        chk(busy == 0, "R7", "stop after flow 00 descriptor", 32'(busy), 0);

        // R8: two-word ring descriptors, length/config retained
        mem[20] = 32'd24; mem[21] = 32'd500;
        mem[24] = 32'd20; mem[25] = 32'd600;
        write_reg(2'd3, 32'd20);
        write_reg(2'd1, 32'd2);
        write_reg(2'd2, mk_cfg(3, 1, 1'b1, 2));
        start_chan();
        watch_buffer(32'd500, 2, 2, 1, "R8");
        watch_buffer(32'd600, 2, 2, 1, "R8");
        watch_buffer(32'd500, 2, 2, 1, "R8");
        chk(busy == 1, "R8", "ring keeps running", 32'(busy), 1);
        do_reset();

        // R9: one-word array entries, terminated by all-ones
        mem[30] = 32'd700; mem[31] = 32'd800; mem[32] = 32'hFFFF_FFFF;
        write_reg(2'd3, 32'd30);
        write_reg(2'd1, 32'd2);
        write_reg(2'd2, mk_cfg(2, 1, 1'b0, 3));
        start_chan();
        watch_buffer(32'd700, 2, 3, 1, "R9");
        watch_buffer(32'd800, 2, 3, 1, "R9");
        repeat (8) @(negedge clk);
        chk(busy == 0 && xfer_req == 0, "R9", "stop on all-ones entry",
            {30'd0, busy, xfer_req}, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule